// File: doc/BRIEF.md
# Periodic Conversion Pacer with Busy-Edge Capture Trigger

This block paces an external sampling converter. While a run enable is set and a nonzero period is programmed, it raises a conversion-start strobe once every `period` system clock cycles. The strobe stays high for a fixed number of cycles, set by a parameter. Software must choose a period at least as long as the converter's conversion time (1.25 us) at the clock rate in use.

The converter answers each start by raising its busy line. Its results may be read only after busy drops. Busy arrives asynchronously, so the block passes it through a two-flop synchronizer. It then emits a single-cycle capture trigger on every falling edge of the synchronized level, and the capture logic that reads the results watches that trigger.

A watchdog covers each conversion. If no busy falling edge is detected within a parameterized number of cycles after a conversion start, a sticky timeout flag is raised. Only reset clears the flag.

Top module: `conv_pacer`

## Requirements
- R1: After reset, `conv_start`, `capture_trig` and `timeout_flag` are all 0.
- R2: With `run_en`=1 and `period`=P>`PULSE_LEN`, `conv_start` is high for exactly `PULSE_LEN` cycles out of every P cycles. The first rise comes P clock edges after the edge at which `run_en` is first seen high.
- R3: Clearing `run_en` forces `conv_start` low in the same cycle and restarts the count. After `run_en` is set again, the first rise comes one full period later.
- R4: A `period` of 0 acts as disabled, and `conv_start` never rises.
- R5: `busy_async` is sampled through two flops. A fall seen at clock edge F gives `capture_trig`=1 for exactly the one cycle between edges F+1 and F+2. A busy level that does not fall gives no trigger.
- R6: If no capture trigger occurs within `TIMEOUT_CYC` cycles after a conversion start, `timeout_flag` goes to 1. It then stays at 1 until reset.
- R7: If `period` is lowered below the current count while running, the next conversion start begins at the next clock edge, and the count does not wrap through its full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enables the conversion-start pulse train |
| period | input | CNT_W | Conversion period in clock cycles (0 = disabled) |
| busy_async | input | 1 | Asynchronous busy level from the converter |
| conv_start | output | 1 | Active-high conversion-start strobe |
| capture_trig | output | 1 | One-cycle pulse on each synchronized busy fall |
| timeout_flag | output | 1 | Sticky flag: a conversion never finished |

## Verification
If the period counter holds a wrong value, the ports show it within one period: `conv_start` rises early, rises late or does not rise at all, and the cycle-by-cycle model flags the first wrong cycle. A fault in the synchronizer chain moves `capture_trig` off its fixed slot, two edges after the sampled fall, or makes it wider than one cycle, and this shows on the next busy fall. A wrong watchdog count shows as `timeout_flag` rising one or more cycles away from `TIMEOUT_CYC` after a start that got no response, or as `timeout_flag` not staying set.

// File: rtl/conv_pacer.sv
module conv_pacer #(
  parameter int CNT_W       = 16,
  parameter int PULSE_LEN   = 4,
  parameter int TIMEOUT_CYC = 64,
  localparam int PL_W = $clog2(PULSE_LEN + 1),
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period,
  input  logic             busy_async,
  output logic             conv_start,
  output logic             capture_trig,
  output logic             timeout_flag
);
  logic [CNT_W-1:0] tick;
  logic [PL_W-1:0]  pulse_left;
  logic [2:0]       busy_sh;
  logic [TO_W-1:0]  wait_cnt;
  logic             waiting;

  wire active  = run_en && (period != '0);
  wire wrap    = active && (tick >= period - 1'b1);

  assign conv_start   = active && (pulse_left != '0);
  assign capture_trig = busy_sh[2] && !busy_sh[1];

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      tick       <= '0;
      pulse_left <= '0;
    end else if (wrap) begin
      tick       <= '0;
      pulse_left <= PL_W'(PULSE_LEN);
    end else begin
      tick <= tick + 1'b1;
      if (pulse_left != '0) pulse_left <= pulse_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_sh <= '0;
    else        busy_sh <= {busy_sh[1:0], busy_async};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting      <= 1'b0;
      wait_cnt     <= '0;
      timeout_flag <= 1'b0;
    end else if (wrap) begin
      waiting  <= 1'b1;
      wait_cnt <= '0;
    end else if (waiting) begin
      if (capture_trig) begin
        waiting <= 1'b0;
      end else if (wait_cnt == TO_W'(TIMEOUT_CYC - 1)) begin
        waiting      <= 1'b0;
        timeout_flag <= 1'b1;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

module conv_pacer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic [CNT_W-1:0] period,
  input logic             conv_start,
  input logic             capture_trig,
  input logic             timeout_flag
);
  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_trig |=> !capture_trig);
  // R3
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !conv_start);
  // R4
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !conv_start);
  // R6
  sticky_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!capture_trig && !timeout_flag));
endmodule

bind conv_pacer conv_pacer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .period(period),
  .conv_start(conv_start), .capture_trig(capture_trig),
  .timeout_flag(timeout_flag));

// File: tb/sim_conv_pacer.sv
module sim_conv_pacer;
  localparam int W = 16, PL = 4, TO = 64, BUSY_CYC = 8;

  logic clk = 0, rst_n = 0, run_en = 0, busy_async = 0;
  logic [W-1:0] period = '0;
  logic conv_start, capture_trig, timeout_flag;
  int vectors = 0, errors = 0;
  bit adc_mute = 0;

  always #4 clk = ~clk;

  conv_pacer #(.CNT_W(W), .PULSE_LEN(PL), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period(period),
    .busy_async(busy_async), .conv_start(conv_start),
    .capture_trig(capture_trig), .timeout_flag(timeout_flag));

  // behavioural reference state
  int  since_start, pulses_left, watch_age;
  bit  watching, m_flag;
  bit  hist [3];

  function automatic bit m_active();
    return run_en && (period != 0);
  endfunction

  always @(posedge clk) begin
    bit trig_before;
    trig_before = hist[2] && !hist[1];
    if (!rst_n) begin
      since_start = 0; pulses_left = 0; watch_age = 0;
      watching = 0; m_flag = 0; hist = '{0, 0, 0};
    end else begin
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = busy_async;
      if (m_active() && since_start + 1 >= int'(period)) begin
        since_start = 0; pulses_left = PL; watching = 1; watch_age = 0;
      end else begin
        if (m_active()) begin
          since_start++;
          if (pulses_left > 0) pulses_left--;
        end else begin
          since_start = 0; pulses_left = 0;
        end
        if (watching) begin
          watch_age++;
          if (trig_before) watching = 0;
          else if (watch_age >= TO) begin watching = 0; m_flag = 1; end
        end
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R2 conv_start", conv_start, m_active() && pulses_left != 0);
      check("R5 capture_trig", capture_trig, hist[2] && !hist[1]);
      check("R6 timeout_flag", timeout_flag, m_flag);
    end
  end

  // converter model
  logic prev_cs = 0;
  int busy_left = 0;
  always @(negedge clk) begin
    if (conv_start && !prev_cs && !adc_mute) busy_left = BUSY_CYC;
    prev_cs = conv_start;
    if (busy_left > 0) begin busy_async <= 1; busy_left--; end
    else busy_async <= 0;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  int rises;
  bit last_cs;
  task automatic count_rises(input int n);
    rises = 0; last_cs = conv_start;
    repeat (n) begin
      @(negedge clk); #3;
      if (conv_start && !last_cs) rises++;
      last_cs = conv_start;
    end
  endtask

  initial begin
    fork
      begin
        cycles(3);
        #2;
        check("R1 conv_start", conv_start, 0);
        check("R1 capture_trig", capture_trig, 0);
        check("R1 timeout_flag", timeout_flag, 0);
        @(negedge clk); rst_n = 1;

        // R2: steady pacing
        period = 20; run_en = 1;
        count_rises(90);
        vectors++;
        if (rises != 4) begin errors++; $display("FAIL R2 rises got %0d expected 4", rises); end

        // R3: stop mid-pulse, then one full period on restart
        @(posedge conv_start);
        @(negedge clk); run_en = 0; #1;
        check("R3 stop", conv_start, 0);
        cycles(5);
        run_en = 1;
        begin
          int seen = 0;
          for (int i = 1; i <= 40; i++) begin
            @(negedge clk); #3;
            if (conv_start && seen == 0) seen = i;
          end
          vectors++;
          if (seen != 20) begin errors++; $display("FAIL R3 restart delay got %0d expected 20", seen); end
        end

        // R4: zero period
        @(negedge clk); period = 0;
        count_rises(50);
        vectors++;
        if (rises != 0) begin errors++; $display("FAIL R4 rises got %0d expected 0", rises); end

        // R7: period cut below running count
        @(negedge clk); period = 40; run_en = 0;
        @(negedge clk); run_en = 1;
        cycles(30);
        period = 10;
        cycles(1); #3;
        check("R7 early wrap", conv_start, 1);
        cycles(40);

        // R6: converter silent -> sticky timeout
        @(negedge clk); adc_mute = 1; period = 200; run_en = 0;
        @(negedge clk); run_en = 1;
        cycles(200 + TO + 5); #3;
        check("R6 set", timeout_flag, 1);
        adc_mute = 0;
        cycles(250); #3;
        check("R6 sticky", timeout_flag, 1);

        // R1: reset clears again
        @(negedge clk); rst_n = 0; run_en = 0;
        cycles(2); #2;
        check("R1 flag cleared", timeout_flag, 0);
        check("R1 start low", conv_start, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule